// File: doc/BRIEF.md
# Frame Sample Buffer with Watermark

This block is a byte-wide sample buffer that sits between a measurement engine and a host register port. Each accepted measurement becomes a frame: a tag byte followed by the enabled 24-bit results, least significant byte first. The frame is copied into a circular store one byte per cycle and becomes visible to the host only when its last byte is in place. The host drains the store oldest byte first through a single data address, where every read moves on to the next byte. It can also read the fill level and program a watermark.

Configuration selects which results go into a frame and whether a frame that does not fit is dropped or pushes out the oldest whole frames. A power-of-two decimator can store one sample out of every 2^k. When the buffer runs dry after holding data, a time-stamp frame can be returned in place of the empty marker. Two command codes clear the buffer. One keeps the configuration and the other restores all settings to zero.

Top module: `sample_fifo`

## Requirements
- R1: After reset the fill level reads 0, both configuration registers and the watermark read 0, and a data read returns the empty marker 0x80.
- R2: Register map: address 0 is data, 1 is level bits 7..0, 2 is level bits 15..8, 3 and 4 are the watermark low and high bytes, 5 is configuration A, 6 is configuration B and 7 is the command. Configuration A bits: 0 enable, 1 stop-when-full, 2 time frame, 3 pressure, 4 temperature. When enabled with at least one result selected, a sample stores a frame made of the tag 0x90 | {temperature, pressure} (temperature in bit 1), then the temperature bytes if selected, then the pressure bytes, each LSB first. The level rises by 4 or 7. With the enable bit clear, or with no result selected, nothing is stored.
- R3: A read of address 0 while the level is non-zero returns the oldest stored byte and lowers the level by exactly one.
- R4: A read of address 0 with the level at 0 returns the empty marker 0x80 (unless R9 applies) and leaves the level at 0.
- R5: With k in configuration B bits 2..0, counting the samples accepted while enabled from the last clear, only samples 0, 2^k, 2·2^k, ... are stored.
- R6: With stop-when-full set, a frame larger than the free space is discarded whole and the stored contents and level stay as they were.
- R7: With stop-when-full clear, a frame larger than the free space removes the oldest frames whole (the unread rest of one the host has begun) until it fits, and is then stored.
- R8: The watermark output is high exactly when the watermark is non-zero and the level is greater than or equal to it. Watermark high-byte bits above the level width read back as 0.
- R9: With configuration A bit 2 set, the first data reads on an empty buffer after a frame was stored return 0xA0 and then the time-stamp input (latched at the 0xA0 read) LSB first. Later empty reads return 0x80.
- R10: Writing 0xB0 to address 7 empties the buffer and restarts the decimator, and leaves the configuration and the watermark unchanged.
- R11: Writing 0xB6 to address 7 empties the buffer and clears the configuration and the watermark. Other command values change nothing.
- R12: A sample presented while a frame is still being checked or written is ignored and is not counted by the decimator. The level never shows part of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a data read consumes a byte |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, valid in the same cycle as the address |
| smpValid | input | 1 | One-cycle pulse: new measurement on the sample inputs |
| smpPress | input | 24 | Pressure result |
| smpTemp | input | 24 | Temperature result |
| timeStamp | input | 24 | Running time count used for the time frame |
| wmReached | output | 1 | Level at or above a non-zero watermark |

## Verification
Most internal faults show at the ports at the next read. A read pointer or an eviction length that is off shows up as a wrong byte in the drained stream. In the sweep every frame can be checked, because each sample carries distinct data. Counting errors show as a wrong level register value in the cycle after the frame commits, well before the drain. A decimator or drop-policy fault changes how many frames are present, and this is read back after each push against the level a byte-queue model predicts.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  localparam logic [7:0] EMPTY_MARK  = 8'h80;
  localparam logic [7:0] DATA_TAG    = 8'h90;
  localparam logic [7:0] TIME_TAG    = 8'hA0;
  localparam logic [7:0] CMD_FLUSH   = 8'hB0;
  localparam logic [7:0] CMD_SOFTRST = 8'hB6;

  localparam logic [2:0] A_DATA   = 3'd0;
  localparam logic [2:0] A_LVL_LO = 3'd1;
  localparam logic [2:0] A_LVL_HI = 3'd2;
  localparam logic [2:0] A_WM_LO  = 3'd3;
  localparam logic [2:0] A_WM_HI  = 3'd4;
  localparam logic [2:0] A_CFG_A  = 3'd5;
  localparam logic [2:0] A_CFG_B  = 3'd6;
  localparam logic [2:0] A_CMD    = 3'd7;

  localparam int CFG_EN    = 0;
  localparam int CFG_STOP  = 1;
  localparam int CFG_TIME  = 2;
  localparam int CFG_PRESS = 3;
  localparam int CFG_TEMP  = 4;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_EVICT, S_WRITE} wrStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic       flush;
    logic       capture;
    logic [7:0] tag;
    logic       write;
    logic [2:0] idx;
    logic       commit;
    logic [2:0] len;
    logic       evict;
    logic       dataRd;
  } dpStrobeT;

  // bytes in a frame: tag plus three per selected result
  function automatic logic [2:0] tagLen(input logic [7:0] tag);
    return 3'd1 + (tag[0] ? 3'd3 : 3'd0) + (tag[1] ? 3'd3 : 3'd0);
  endfunction

endpackage

// File: rtl/sfifo_dp.sv
module sfifo_dp
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CNT_W = 10,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strb,
  input  logic [23:0]      smpPress,
  input  logic [23:0]      smpTemp,
  input  logic [23:0]      timeStamp,
  input  logic             timeEn,
  output logic [CNT_W-1:0] level,
  output logic [7:0]       dataByte
);

  logic [7:0]       mem [DEPTH];
  logic [55:0]      stageQ;
  logic [55:0]      frameBits;
  logic [AW-1:0]    rdPtr, wrPtr;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [2:0]       headLeft;
  logic [2:0]       headLen, evLen;
  logic [7:0]       headTag, stageByte;
  logic             pop;
  logic [1:0]       tIdx;
  logic             tDone;
  logic [23:0]      tLatch;
  logic             timeRd;

  assign level   = cnt;
  assign headTag = mem[rdPtr];
  assign headLen = tagLen(headTag);
  assign evLen   = (headLeft != 3'd0) ? headLeft : headLen;
  assign pop     = strb.dataRd && (cnt != '0);
  assign timeRd  = strb.dataRd && (cnt == '0) && timeEn && !tDone;

  // frame layout: tag, temperature (if selected), pressure (if selected)
  always_comb begin
    if (strb.tag[1]) frameBits = {smpPress, smpTemp, strb.tag};
    else             frameBits = {24'h0, smpPress, strb.tag};
  end

  always_ff @(posedge clk) begin
    if (strb.capture) stageQ <= frameBits;
  end

  assign stageByte = stageQ[8*strb.idx +: 8];

  always_ff @(posedge clk) begin
    if (strb.write && !strb.flush) mem[wrPtr + AW'(strb.idx)] <= stageByte;
  end

  always_comb begin
    cntNext = cnt;
    if (strb.commit) cntNext = cntNext + CNT_W'(strb.len);
    if (pop)         cntNext = cntNext - CNT_W'(1);
    if (strb.evict)  cntNext = cntNext - CNT_W'(evLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      cnt      <= '0;
      headLeft <= '0;
    end else if (strb.flush) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      cnt      <= '0;
      headLeft <= '0;
    end else begin
      cnt <= cntNext;
      if (strb.commit) wrPtr <= wrPtr + AW'(strb.len);
      if (strb.evict) begin
        rdPtr    <= rdPtr + AW'(evLen);
        headLeft <= '0;
      end else if (pop) begin
        rdPtr    <= rdPtr + AW'(1);
        headLeft <= (headLeft == 3'd0) ? headLen - 3'd1 : headLeft - 3'd1;
      end
    end
  end

  // time-stamp frame returned once the buffer runs dry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tIdx   <= '0;
      tDone  <= 1'b1;
      tLatch <= '0;
    end else if (strb.flush) begin
      tIdx  <= '0;
      tDone <= 1'b1;
    end else if (strb.commit) begin
      tIdx  <= '0;
      tDone <= 1'b0;
    end else if (timeRd) begin
      if (tIdx == 2'd0) tLatch <= timeStamp;
      tIdx <= tIdx + 2'd1;
      if (tIdx == 2'd3) tDone <= 1'b1;
    end
  end

  always_comb begin
    if (cnt != '0) dataByte = headTag;
    else if (timeEn && !tDone) begin
      case (tIdx)
        2'd0:    dataByte = TIME_TAG;
        2'd1:    dataByte = tLatch[7:0];
        2'd2:    dataByte = tLatch[15:8];
        default: dataByte = tLatch[23:16];
      endcase
    end else dataByte = EMPTY_MARK;
  end

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));

  assert_commit_room_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.flush) |-> ((CNT_W+1)'(cnt) + (CNT_W+1)'(strb.len) <= (CNT_W+1)'(DEPTH)));

  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !strb.commit && !strb.evict && !strb.flush) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataRd && (cnt == '0) && !strb.commit && !strb.flush) |=> (cnt == '0));

  assert_evict_no_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.evict |-> !pop);

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [2:0]       regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             smpValid,
  input  logic [CNT_W-1:0] level,
  input  logic [7:0]       dataByte,
  output dpStrobeT         strb,
  output logic             timeEn,
  output logic             wmReached
);

  localparam int         HI_BITS = (CNT_W > 8) ? CNT_W - 8 : 0;
  localparam logic [7:0] HI_MASK = 8'((16'd1 << HI_BITS) - 16'd1);

  logic [4:0]       cfgA;
  logic [2:0]       cfgB;
  logic [7:0]       wmLo, wmHi;
  wrStateT          state;
  logic [7:0]       tagQ, newTag;
  logic [2:0]       lenQ, idxQ;
  logic [6:0]       subCnt, subMask;
  logic             cmdFlush, cmdRst, flushAll;
  logic             dataRd, popNow, smpTake, store, fits;
  logic [CNT_W-1:0] freeBytes;
  logic [15:0]      lvl16, wm16;

  assign cmdFlush = regWrEn && (regAddr == A_CMD) && (regWrData == CMD_FLUSH);
  assign cmdRst   = regWrEn && (regAddr == A_CMD) && (regWrData == CMD_SOFTRST);
  assign flushAll = cmdFlush || cmdRst;
  assign dataRd   = regRdEn && (regAddr == A_DATA);
  assign popNow   = dataRd && (level != '0);

  assign subMask  = 7'((8'h01 << cfgB) - 8'h01);
  assign newTag   = DATA_TAG | {6'b0, cfgA[CFG_TEMP], cfgA[CFG_PRESS]};
  assign smpTake  = smpValid && (state == S_IDLE) && cfgA[CFG_EN];
  assign store    = smpTake && ((subCnt & subMask) == '0) && (cfgA[CFG_TEMP] || cfgA[CFG_PRESS]);

  assign freeBytes = CNT_W'(DEPTH) - level;
  assign fits      = CNT_W'(lenQ) <= freeBytes;
  assign timeEn    = cfgA[CFG_TIME];

  // configuration and watermark registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgA <= '0;
      cfgB <= '0;
      wmLo <= '0;
      wmHi <= '0;
    end else if (cmdRst) begin
      cfgA <= '0;
      cfgB <= '0;
      wmLo <= '0;
      wmHi <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        A_WM_LO: wmLo <= regWrData;
        A_WM_HI: wmHi <= regWrData & HI_MASK;
        A_CFG_A: cfgA <= regWrData[4:0];
        A_CFG_B: cfgB <= regWrData[2:0];
        default: ;
      endcase
    end
  end

  // frame writer: capture, room check, eviction, byte writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      tagQ   <= '0;
      lenQ   <= '0;
      idxQ   <= '0;
      subCnt <= '0;
    end else if (flushAll) begin
      state  <= S_IDLE;
      idxQ   <= '0;
      subCnt <= '0;
    end else begin
      if (smpTake) subCnt <= (subCnt + 7'd1) & subMask;
      case (state)
        S_IDLE: if (store) begin
          tagQ  <= newTag;
          lenQ  <= tagLen(newTag);
          state <= S_CHECK;
        end
        S_CHECK: begin
          if (fits) begin
            idxQ  <= '0;
            state <= S_WRITE;
          end else if (cfgA[CFG_STOP]) state <= S_IDLE;
          else state <= S_EVICT;
        end
        S_EVICT: if (!popNow) state <= S_CHECK;
        S_WRITE: begin
          if (idxQ == lenQ - 3'd1) state <= S_IDLE;
          else idxQ <= idxQ + 3'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.flush   = flushAll;
    strb.capture = store;
    strb.tag     = (state == S_IDLE) ? newTag : tagQ;
    strb.write   = (state == S_WRITE);
    strb.idx     = idxQ;
    strb.commit  = (state == S_WRITE) && (idxQ == lenQ - 3'd1);
    strb.len     = lenQ;
    strb.evict   = (state == S_EVICT) && !popNow;
    strb.dataRd  = dataRd;
  end

  assign lvl16     = 16'(level);
  assign wm16      = {wmHi, wmLo};
  assign wmReached = (wm16 != 16'd0) && (lvl16 >= wm16);

  always_comb begin
    case (regAddr)
      A_DATA:   regRdData = dataByte;
      A_LVL_LO: regRdData = lvl16[7:0];
      A_LVL_HI: regRdData = lvl16[15:8];
      A_WM_LO:  regRdData = wmLo;
      A_WM_HI:  regRdData = wmHi;
      A_CFG_A:  regRdData = {3'b0, cfgA};
      A_CFG_B:  regRdData = {5'b0, cfgB};
      default:  regRdData = 8'h00;
    endcase
  end

  assert_flush_keeps_cfg_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdFlush |=> (cfgA == $past(cfgA)) && (cfgB == $past(cfgB)) && (wm16 == $past(wm16)));

  assert_softrst_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdRst |=> (cfgA == '0) && (cfgB == '0) && (wm16 == 16'd0));

  assert_stop_discards_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_CHECK) && !fits && cfgA[CFG_STOP] && !flushAll) |=> (state == S_IDLE));

  assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !strb.capture);

endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        smpValid,
  input  logic [23:0] smpPress,
  input  logic [23:0] smpTemp,
  input  logic [23:0] timeStamp,
  output logic        wmReached
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  dpStrobeT         strb;
  logic [CNT_W-1:0] level;
  logic [7:0]       dataByte;
  logic             timeEn;

  sfifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .smpValid(smpValid), .level(level), .dataByte(dataByte),
    .strb(strb), .timeEn(timeEn), .wmReached(wmReached)
  );

  sfifo_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .smpPress(smpPress), .smpTemp(smpTemp), .timeStamp(timeStamp),
    .timeEn(timeEn), .level(level), .dataByte(dataByte)
  );

endmodule

// File: tb/sample_fifo_bench.sv
module sample_fifo_bench;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic        smpValid = 1'b0;
  logic [23:0] smpPress = '0, smpTemp = '0, timeStamp = '0;
  logic        wmReached;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  logic [7:0]  q[$];
  int          fl[$];
  logic [4:0]  mCfgA = '0;
  logic [2:0]  mCfgB = '0;
  int          mSub = 0;
  bit          mTimeDone = 1;
  int          mTIdx = 0;
  logic [23:0] mStamp = '0;

  always #2 clk = ~clk;

  sample_fifo #(.DEPTH(DEPTH)) u_sample_fifo (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .smpValid(smpValid), .smpPress(smpPress), .smpTemp(smpTemp),
    .timeStamp(timeStamp), .wmReached(wmReached)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic modelClear();
    q.delete(); fl.delete(); mSub = 0; mTimeDone = 1; mTIdx = 0;
  endtask

  task automatic flushCmd();
    wrReg(3'd7, 8'hB0);
    modelClear();
  endtask

  task automatic setCfgA(input logic [4:0] v);
    wrReg(3'd5, {3'b0, v}); mCfgA = v;
  endtask

  task automatic setCfgB(input logic [2:0] v);
    wrReg(3'd6, {5'b0, v}); mCfgB = v;
  endtask

  task automatic checkLevel(input string req);
    logic [7:0] lo, hi;
    rdReg(3'd1, lo);
    rdReg(3'd2, hi);
    check(req, {hi, lo}, q.size());
  endtask

  task automatic readData(input string req);
    logic [7:0] exp, got;
    if (q.size() > 0) begin
      exp = q.pop_front();
      fl[0] = fl[0] - 1;
      if (fl[0] == 0) void'(fl.pop_front());
    end else if (mCfgA[2] && !mTimeDone) begin
      case (mTIdx)
        0: begin exp = 8'hA0; mStamp = timeStamp; end
        1: exp = mStamp[7:0];
        2: exp = mStamp[15:8];
        default: exp = mStamp[23:16];
      endcase
      if (mTIdx == 3) begin mTIdx = 0; mTimeDone = 1; end
      else mTIdx++;
    end else exp = 8'h80;
    @(negedge clk);
    regAddr = 3'd0; regRdEn = 1'b1;
    #1 got = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
    check(req, got, exp);
  endtask

  task automatic modelStore(input logic [23:0] p, input logic [23:0] t);
    logic [7:0] fr[7];
    int len, mask;
    if (!mCfgA[0]) return;
    mask = (1 << mCfgB) - 1;
    if (((mSub & mask) == 0) && (mCfgA[3] || mCfgA[4])) begin
      fr[0] = 8'h90 | {6'b0, mCfgA[4], mCfgA[3]};
      len = 1;
      if (mCfgA[4]) begin
        fr[1] = t[7:0]; fr[2] = t[15:8]; fr[3] = t[23:16]; len = 4;
      end
      if (mCfgA[3]) begin
        fr[len] = p[7:0]; fr[len+1] = p[15:8]; fr[len+2] = p[23:16]; len += 3;
      end
      if (len > DEPTH - q.size() && mCfgA[1]) begin
        // stop-when-full: frame discarded
      end else begin
        while (len > DEPTH - q.size()) begin
          repeat (fl[0]) void'(q.pop_front());
          void'(fl.pop_front());
        end
        for (int i = 0; i < len; i++) q.push_back(fr[i]);
        fl.push_back(len);
        mTimeDone = 0; mTIdx = 0;
      end
    end
    mSub = (mSub + 1) & mask;
  endtask

  task automatic pushSample(input logic [23:0] p, input logic [23:0] t);
    @(negedge clk);
    smpPress = p; smpTemp = t; smpValid = 1'b1;
    @(negedge clk);
    smpValid = 1'b0;
    modelStore(p, t);
    repeat (24) @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) readData(req);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkLevel("R1 level after reset");
    rdReg(3'd5, v); check("R1 cfgA after reset", v, 0);
    rdReg(3'd6, v); check("R1 cfgB after reset", v, 0);
    rdReg(3'd3, v); check("R1 watermark after reset", v, 0);
    check("R1 wmReached after reset", wmReached, 0);
    readData("R1 empty marker after reset");
    checkLevel("R4 level unchanged by empty read");

    // R2 R3: single pressure frame
    setCfgA(5'b01001);
    pushSample(24'h332211, 24'h665544);
    checkLevel("R2 level after pressure frame");
    drain("R3 pressure frame order");
    checkLevel("R3 level after drain");
    readData("R4 empty read");

    // R6 R7 R2: sweep content selection x full policy
    for (int pt = 1; pt <= 3; pt++) begin
      for (int st = 0; st < 2; st++) begin
        flushCmd();
        setCfgA(5'((pt << 3) | (st << 1) | 1));
        for (int s = 0; s < 5; s++) begin
          pushSample(24'h0A0B0C + 24'(s * 24'h111111 + pt), 24'hF01020 + 24'(s * 24'h010101 + st));
          checkLevel(st ? "R6 level with stop-when-full" : "R7 level with overwrite");
        end
        drain(st ? "R6 contents after discard" : "R7 contents after eviction");
        readData("R4 empty after sweep drain");
      end
    end

    // R7: eviction of a partly read frame
    flushCmd();
    setCfgA(5'b11001);
    pushSample(24'h123456, 24'h789ABC);
    pushSample(24'h13579B, 24'h2468AC);
    for (int i = 0; i < 3; i++) readData("R3 partial read");
    pushSample(24'hDEF012, 24'h345678);
    checkLevel("R7 level after evicting partial frame");
    drain("R7 contents after evicting partial frame");

    // R5: decimation for k = 0..3
    for (int k = 0; k < 4; k++) begin
      flushCmd();
      setCfgB(3'(k));
      setCfgA(5'b01011);
      for (int s = 0; s < 8; s++) begin
        pushSample(24'h400000 + 24'(s * 7 + k), 24'h0);
        checkLevel("R5 level under decimation");
      end
      drain("R5 stored samples");
    end
    setCfgB(3'd0);

    // R8: watermark
    flushCmd();
    setCfgA(5'b01011);
    wrReg(3'd3, 8'd8);
    wrReg(3'd4, 8'hFF);
    rdReg(3'd4, v); check("R8 watermark high bits absent", v, 0);
    check("R8 below watermark at 0", wmReached, 0);
    pushSample(24'h000001, 24'h0);
    check("R8 level 4 below 8", wmReached, 0);
    pushSample(24'h000002, 24'h0);
    check("R8 level 8 at watermark", wmReached, 1);
    readData("R3 read before watermark drop");
    @(negedge clk);
    check("R8 level 7 below watermark", wmReached, 0);
    wrReg(3'd3, 8'd0);
    check("R8 zero watermark disables", wmReached, 0);
    drain("R3 drain after watermark test");

    // R9: time frame
    flushCmd();
    setCfgA(5'b01101);
    timeStamp = 24'h654321;
    readData("R9 no time frame before any data");
    pushSample(24'hA1B2C3, 24'h0);
    drain("R9 frame before time frame");
    readData("R9 time tag");
    timeStamp = 24'h000000;
    readData("R9 time byte 0");
    readData("R9 time byte 1");
    readData("R9 time byte 2");
    readData("R9 marker after time frame");
    checkLevel("R9 level unchanged by time frame");

    // R10: flush keeps configuration
    setCfgA(5'b11011);
    wrReg(3'd3, 8'd5);
    pushSample(24'h0F0E0D, 24'h0C0B0A);
    flushCmd();
    checkLevel("R10 level after flush");
    rdReg(3'd5, v); check("R10 cfgA kept", v, 8'h1B);
    rdReg(3'd3, v); check("R10 watermark kept", v, 5);
    readData("R10 marker after flush");

    // R11: other commands ignored, soft reset clears
    pushSample(24'h111111, 24'h222222);
    wrReg(3'd7, 8'h55);
    checkLevel("R11 unknown command keeps data");
    rdReg(3'd5, v); check("R11 unknown command keeps cfgA", v, 8'h1B);
    wrReg(3'd7, 8'hB6);
    modelClear(); mCfgA = '0; mCfgB = '0;
    checkLevel("R11 level after soft reset");
    rdReg(3'd5, v); check("R11 cfgA cleared", v, 0);
    rdReg(3'd3, v); check("R11 watermark cleared", v, 0);

    // R2: disabled or nothing selected stores nothing
    setCfgA(5'b11000);
    pushSample(24'h777777, 24'h888888);
    checkLevel("R2 disabled stores nothing");
    setCfgA(5'b00001);
    pushSample(24'h777777, 24'h888888);
    checkLevel("R2 no result selected stores nothing");

    // R12: back-to-back sample ignored while busy
    setCfgA(5'b01001);
    @(negedge clk);
    smpPress = 24'hAAAAAA; smpValid = 1'b1;
    @(negedge clk);
    smpPress = 24'hBBBBBB;
    @(negedge clk);
    smpValid = 1'b0;
    modelStore(24'hAAAAAA, 24'h0);
    repeat (24) @(negedge clk);
    checkLevel("R12 second sample ignored");
    drain("R12 only first frame stored");

    done = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog R1..R12 run actual=timeout expected=completion");
      summary();
    end
  end

endmodule